// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This block takes single write requests from an on-chip requester and plays each one out on an asynchronous external memory bus. The bus has a 22-bit address, 16-bit data with a separate drive enable, active-low write and read strobes, and six active-low space selects. Four of the selects are memory banks, one is an I/O space and one is a boot space. The controller runs on a clock at twice the bus-clock rate. It keeps a phase bit (`bus_ph`, 0 in the first half of each bus clock), which lets it place edges on half-bus-clock boundaries.

Each space carries static configuration: a 3-bit waitstate count W, a 2-bit stretch mode and a write-hold enable. The mode picks how the strobe is stretched: by the waitstate count alone, by the acknowledge input alone, or by the full waitstate count followed by acknowledge. The requester uses a ready/valid handshake. A one-cycle `done` pulse marks the return of the bus to idle.

Top module: `ebw_write_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are idle: `bus_wr_n`, `bus_rd_n` and all of `bus_sel_n` high, `bus_data_oe` low and `done` low. This holds even when reset arrives in the middle of an access.
- R2: `req_ready` is high only when the controller is idle and `bus_ph` is 0. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle in which the one-cycle `done` pulse is high. That cycle comes two cycles after the strobe rises.
- R3: Space code 0..3 drives `bus_sel_n[code]` low (banks), code 4 drives bit 4 (I/O) and code 5 drives bit 5 (boot). At most one select is low at any time. Codes 6 and 7 drive no select and run as waitstates-only with W=0 and no write hold.
- R4: Select and address become valid one cycle (half a bus clock) before `bus_wr_n` falls. The fall always happens in a cycle with `bus_ph` = 0.
- R5: Mode 0 (field `cfg_mode[2s+1:2s]` = 0): `bus_wr_n` stays low for 2*(1+W) cycles, where W = `cfg_wait[3s+2:3s]` for space s.
- R6: Mode 1 (acknowledge only): the strobe is low for one bus clock. After that, `bus_ack` is sampled at each clock edge that ends a `bus_ph` = 1 cycle. The strobe stays low while the sample is 0. After the first sample that is 1, the strobe stays low for two more bus clocks (4 cycles), giving 2*(1+n+2) cycles for n low samples.
- R7: Modes 2 and 3 (combined): all W waitstates are counted first. Acknowledge is then handled as in R6, for 2*(1+W+n+2) cycles in total.
- R8: `bus_ack` has no effect in mode 0. In the other modes it has no effect in `bus_ph` = 0 cycles.
- R9: Select and address remain asserted for exactly one cycle after `bus_wr_n` rises, then the selects go high.
- R10: `bus_data_oe` is high, and `bus_data` holds the request data, throughout the strobe. With the space's `cfg_whc` bit at 0, the drive ends as the strobe rises. With the bit at 1, it continues for two more cycles (one bus clock).
- R11: Between two write strobes, `bus_wr_n` stays high for at least four cycles (two bus clocks).
- R12: `bus_rd_n` is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, twice the bus-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_space | input | 3 | Target space code |
| req_addr | input | 22 | Write address |
| req_data | input | 16 | Write data |
| done | output | 1 | One-cycle pulse: access finished, bus idle |
| cfg_wait | input | 18 | Waitstate count per space, 3 bits each |
| cfg_mode | input | 12 | Stretch mode per space, 2 bits each |
| cfg_whc | input | 6 | Write-hold enable per space |
| bus_ack | input | 1 | External acknowledge, high = ready |
| bus_ph | output | 1 | Half-period phase of the bus clock |
| bus_addr | output | 22 | External address |
| bus_data | output | 16 | External write data |
| bus_data_oe | output | 1 | Data drive enable |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low, held inactive |
| bus_sel_n | output | 6 | Space selects, active low |

## Verification
The bench measures strobe width at the largest waitstate count and at zero. A counter that is off by one gives a pulse two cycles wrong. It holds acknowledge low for several samples, and it pulses acknowledge high only in `bus_ph` = 0 cycles; a design that samples in the wrong phase ends those accesses early. It drives acknowledge high during waitstate-only accesses, and it uses the invalid space codes, where a design that decoded those codes would assert a select or stretch the strobe. A reset in the middle of an access must drop every strobe and select at once. The bench also checks the data hold window with the hold enable on and off, and the strobe gap of back-to-back accesses.

// File: rtl/ebw_pkg.sv
package ebw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ACK   = 3'd3,
    ST_FIN   = 3'd4,
    ST_HOLD  = 3'd5,
    ST_REST  = 3'd6
  } ebw_state_e;

  localparam logic [1:0] MODE_WAIT = 2'd0;
  localparam logic [1:0] MODE_ACK  = 2'd1;

  // strobe periods still to run once acknowledge is seen high
  localparam int ACK_TAIL = 2;

endpackage

// File: rtl/ebw_phase.sv
module ebw_phase (
  input  logic clk,
  input  logic rst_n,
  output logic ph
);

  logic ph_q;
  logic ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;

endmodule

// File: rtl/ebw_cfg_sel.sv
module ebw_cfg_sel #(
  parameter int NSPACE  = 6,
  parameter int WS_W    = 3,
  parameter int SPACE_W = 3
) (
  input  logic [SPACE_W-1:0]     space,
  input  logic [NSPACE*WS_W-1:0] cfg_wait,
  input  logic [NSPACE*2-1:0]    cfg_mode,
  input  logic [NSPACE-1:0]      cfg_whc,
  output logic [WS_W-1:0]        ws,
  output logic [1:0]             mode,
  output logic                   hold,
  output logic [NSPACE-1:0]      hit
);

  for (genvar s = 0; s < NSPACE; s++) begin : g_hit
    assign hit[s] = (space == SPACE_W'(s));
  end

  // hit is one-hot or empty: an empty hit yields zero config
  always_comb begin
    ws   = '0;
    mode = '0;
    hold = 1'b0;
    for (int s = 0; s < NSPACE; s++) begin
      ws   = ws   | ({WS_W{hit[s]}} & cfg_wait[s*WS_W +: WS_W]);
      mode = mode | ({2{hit[s]}} & cfg_mode[s*2 +: 2]);
      hold = hold | (hit[s] & cfg_whc[s]);
    end
  end

endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
  import ebw_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ph,
  input  logic            start,
  input  logic [WS_W-1:0] ws_in,
  input  logic [1:0]      mode_in,
  input  logic            bus_ack,
  output ebw_state_e      state,
  output logic            done
);

  localparam int CNT_W = WS_W + 1;

  ebw_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       mode_q, mode_d;
  logic [WS_W-1:0]  ws_q, ws_d;
  logic             done_q, done_d;
  logic             last_period;

  assign last_period = (cnt_q == CNT_W'(1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    ws_d    = ws_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP;
        mode_d  = mode_in;
        ws_d    = ws_in;
      end
      ST_SETUP: begin
        state_d = ST_WAIT;
        cnt_d   = (mode_q == MODE_ACK) ? CNT_W'(1) : CNT_W'(ws_q) + CNT_W'(1);
      end
      ST_WAIT: if (ph) begin
        if (!last_period) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (mode_q == MODE_WAIT) begin
          state_d = ST_HOLD;
        end else if (bus_ack) begin
          state_d = ST_FIN;
          cnt_d   = CNT_W'(ACK_TAIL);
        end else begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: if (ph && bus_ack) begin
        state_d = ST_FIN;
        cnt_d   = CNT_W'(ACK_TAIL);
      end
      ST_FIN: if (ph) begin
        if (last_period) state_d = ST_HOLD;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      ST_HOLD: state_d = ST_REST;
      ST_REST: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= '0;
      ws_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      ws_q    <= ws_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

endmodule

// File: rtl/ebw_write_ctrl.sv
module ebw_write_ctrl
  import ebw_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WS_W   = 3,
  parameter int NSPACE = 6,
  localparam int SPACE_W = $clog2(NSPACE + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [SPACE_W-1:0]     req_space,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_data,
  output logic                   done,
  input  logic [NSPACE*WS_W-1:0] cfg_wait,
  input  logic [NSPACE*2-1:0]    cfg_mode,
  input  logic [NSPACE-1:0]      cfg_whc,
  input  logic                   bus_ack,
  output logic                   bus_ph,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [DATA_W-1:0]      bus_data,
  output logic                   bus_data_oe,
  output logic                   bus_wr_n,
  output logic                   bus_rd_n,
  output logic [NSPACE-1:0]      bus_sel_n
);

  logic              ph;
  logic              accept;
  ebw_state_e        state;
  logic [WS_W-1:0]   sp_ws;
  logic [1:0]        sp_mode;
  logic              sp_hold;
  logic [NSPACE-1:0] sp_hit;

  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic [NSPACE-1:0] lat_sel;
  logic              lat_hold;

  logic strobe_on, sel_on, tail_on;

  ebw_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .ph    (ph)
  );

  ebw_cfg_sel #(
    .NSPACE  (NSPACE),
    .WS_W    (WS_W),
    .SPACE_W (SPACE_W)
  ) u_cfg (
    .space    (req_space),
    .cfg_wait (cfg_wait),
    .cfg_mode (cfg_mode),
    .cfg_whc  (cfg_whc),
    .ws       (sp_ws),
    .mode     (sp_mode),
    .hold     (sp_hold),
    .hit      (sp_hit)
  );

  assign req_ready = (state == ST_IDLE) && !ph;
  assign accept    = req_valid && req_ready;

  ebw_seq #(
    .WS_W (WS_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph),
    .start   (accept),
    .ws_in   (sp_ws),
    .mode_in (sp_mode),
    .bus_ack (bus_ack),
    .state   (state),
    .done    (done)
  );

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      lat_data <= '0;
      lat_sel  <= '0;
      lat_hold <= 1'b0;
    end else if (accept) begin
      lat_addr <= req_addr;
      lat_data <= req_data;
      lat_sel  <= sp_hit;
      lat_hold <= sp_hold;
    end
  end

  always_comb begin
    strobe_on = (state == ST_WAIT) || (state == ST_ACK) || (state == ST_FIN);
    sel_on    = strobe_on || (state == ST_SETUP) || (state == ST_HOLD);
    tail_on   = (state == ST_HOLD) || (state == ST_REST);
  end

  assign bus_ph      = ph;
  assign bus_addr    = lat_addr;
  assign bus_data    = lat_data;
  assign bus_data_oe = strobe_on || (lat_hold && tail_on);
  assign bus_wr_n    = !strobe_on;
  assign bus_rd_n    = 1'b1;
  assign bus_sel_n   = sel_on ? ~lat_sel : '1;

endmodule

// File: rtl/ebw_write_ctrl_chk.sv
module ebw_write_ctrl_chk #(
  parameter int ADDR_W = 22,
  parameter int NSPACE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              bus_ph,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_data_oe,
  input logic              bus_wr_n,
  input logic              bus_rd_n,
  input logic [NSPACE-1:0] bus_sel_n
);

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_sel_n));

  p_read_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_n);

  p_lead_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> (!bus_ph && bus_sel_n == $past(bus_sel_n)
                         && bus_addr == $past(bus_addr)));

  p_rise_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> !bus_ph);

  p_sel_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_sel_n == $past(bus_sel_n)));

  p_sel_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |=> (bus_sel_n == '1));

  p_data_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_data_oe);

  p_recovery_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |=> bus_wr_n);

  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_wr_n && !bus_data_oe && bus_sel_n == '1));

  p_no_reaccept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind ebw_write_ctrl ebw_write_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .NSPACE (NSPACE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .bus_ph      (bus_ph),
  .bus_addr    (bus_addr),
  .bus_data_oe (bus_data_oe),
  .bus_wr_n    (bus_wr_n),
  .bus_rd_n    (bus_rd_n),
  .bus_sel_n   (bus_sel_n)
);

// File: tb/ebw_write_ctrl_test.sv
module ebw_write_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_space;
  logic [21:0] req_addr;
  logic [15:0] req_data;
  logic        done;
  logic [17:0] cfg_wait;
  logic [11:0] cfg_mode;
  logic [5:0]  cfg_whc;
  logic        bus_ack;
  logic        bus_ph;
  logic [21:0] bus_addr;
  logic [15:0] bus_data;
  logic        bus_data_oe;
  logic        bus_wr_n;
  logic        bus_rd_n;
  logic [5:0]  bus_sel_n;

  int checks;
  int errors;
  int ncyc;
  int last_rise;
  bit have_rise;
  bit finished;

  ebw_write_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_space   (req_space),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .done        (done),
    .cfg_wait    (cfg_wait),
    .cfg_mode    (cfg_mode),
    .cfg_whc     (cfg_whc),
    .bus_ack     (bus_ack),
    .bus_ph      (bus_ph),
    .bus_addr    (bus_addr),
    .bus_data    (bus_data),
    .bus_data_oe (bus_data_oe),
    .bus_wr_n    (bus_wr_n),
    .bus_rd_n    (bus_rd_n),
    .bus_sel_n   (bus_sel_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) ncyc <= ncyc + 1;

  typedef struct packed {
    logic [2:0] space;
    logic [2:0] ws;
    logic [1:0] mode;
    logic       whc;
    logic [3:0] nlow;
    logic       glitch;
    logic [5:0] exp_len;
  } vec_t;

  localparam int NVEC = 11;
  // space, W, mode, hold, low acks, ack glitch, expected strobe cycles
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 2'd0, 1'b0, 4'd0, 1'b0, 6'd2},
    '{3'd1, 3'd3, 2'd0, 1'b1, 4'd0, 1'b0, 6'd8},
    '{3'd2, 3'd7, 2'd0, 1'b0, 4'd0, 1'b0, 6'd16},
    '{3'd3, 3'd0, 2'd1, 1'b0, 4'd0, 1'b0, 6'd6},
    '{3'd4, 3'd0, 2'd1, 1'b1, 4'd3, 1'b0, 6'd12},
    '{3'd5, 3'd2, 2'd2, 1'b0, 4'd0, 1'b0, 6'd10},
    '{3'd0, 3'd1, 2'd3, 1'b1, 4'd2, 1'b0, 6'd12},
    '{3'd1, 3'd0, 2'd1, 1'b0, 4'd2, 1'b1, 6'd10},
    '{3'd6, 3'd0, 2'd1, 1'b1, 4'd2, 1'b0, 6'd2},
    '{3'd7, 3'd3, 2'd2, 1'b1, 4'd0, 1'b0, 6'd2},
    '{3'd3, 3'd5, 2'd0, 1'b0, 4'd0, 1'b1, 6'd12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit         valid_sp;
    logic [1:0] emode;
    logic [2:0] ews;
    bit         ewhc;
    logic [5:0] esel;
    int         base;
    int         k;
    int         lows;
    string      ltag;
    valid_sp = (v.space < 3'd6);
    emode    = valid_sp ? v.mode : 2'd0;
    ews      = valid_sp ? v.ws   : 3'd0;
    ewhc     = valid_sp ? v.whc  : 1'b0;
    esel     = valid_sp ? ~(6'd1 << v.space) : 6'h3F;
    base     = (emode == 2'd1) ? 1 : 1 + int'(ews);
    ltag     = v.glitch ? "R8" : (emode == 2'd0) ? "R5" : (emode == 2'd1) ? "R6" : "R7";
    if (valid_sp) begin
      cfg_wait[v.space*3 +: 3] = v.ws;
      cfg_mode[v.space*2 +: 2] = v.mode;
      cfg_whc[v.space]         = v.whc;
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_space = v.space;
    req_addr  = 22'h2A_0000 | 22'(idx * 22'h1357);
    req_data  = 16'hC300 ^ 16'(idx * 16'h0111);
    for (int g = 0; g < 8 && !req_ready; g++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // setup half-cycle
    chk(bus_wr_n == 1'b1, "R4 setup strobe", int'(bus_wr_n), 1);
    chk(bus_sel_n == esel, "R3 select", int'(bus_sel_n), int'(esel));
    chk(bus_addr == req_addr, "R4 setup addr", int'(bus_addr), int'(req_addr));
    chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
    chk(bus_data_oe == 1'b0, "R10 no early drive", int'(bus_data_oe), 0);
    k = 0;
    lows = 0;
    @(negedge clk);
    while (!bus_wr_n && k < 200) begin
      k++;
      if (k == 1) begin
        chk(bus_ph == 1'b0, "R4 fall phase", int'(bus_ph), 0);
        if (have_rise)
          chk(ncyc - last_rise >= 4, "R11 gap", ncyc - last_rise, 4);
      end
      chk(bus_data_oe && bus_data == req_data, "R10 data drive",
          int'(bus_data), int'(req_data));
      if (emode == 2'd0) begin
        bus_ack = v.glitch;
      end else if (!bus_ph) begin
        bus_ack = v.glitch;
      end else if (k >= 2 * base) begin
        if (lows < int'(v.nlow)) begin
          bus_ack = 1'b0;
          lows++;
        end else begin
          bus_ack = 1'b1;
        end
      end else begin
        bus_ack = 1'b0;
      end
      @(negedge clk);
    end
    last_rise = ncyc;
    have_rise = 1'b1;
    chk(k == int'(v.exp_len), ltag, k, int'(v.exp_len));
    chk(bus_sel_n == esel, "R9 select trail", int'(bus_sel_n), int'(esel));
    chk(bus_data_oe == ewhc, "R10 hold first", int'(bus_data_oe), int'(ewhc));
    bus_ack = 1'b0;
    @(negedge clk);
    chk(bus_sel_n == 6'h3F, "R9 select off", int'(bus_sel_n), 63);
    chk(bus_data_oe == ewhc, "R10 hold second", int'(bus_data_oe), int'(ewhc));
    chk(done == 1'b0, "R2 done early", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R2 done pulse", int'(done), 1);
    chk(bus_data_oe == 1'b0, "R10 released", int'(bus_data_oe), 0);
    chk(req_ready == 1'b1, "R2 ready again", int'(req_ready), 1);
    chk(bus_rd_n == 1'b1, "R12 read strobe", int'(bus_rd_n), 1);
  endtask

  initial begin
    checks = 0; errors = 0; ncyc = 0; last_rise = 0;
    have_rise = 1'b0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_space = '0; req_addr = '0;
    req_data = '0; cfg_wait = '0; cfg_mode = '0; cfg_whc = '0; bus_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_wr_n && bus_rd_n, "R1 strobes idle", int'({bus_wr_n, bus_rd_n}), 3);
    chk(bus_sel_n == 6'h3F, "R1 selects idle", int'(bus_sel_n), 63);
    chk(!bus_data_oe && !done, "R1 drive/done", int'({bus_data_oe, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == !bus_ph, "R2 ready phase", int'(req_ready), int'(!bus_ph));
    @(negedge clk);
    chk(req_ready == !bus_ph, "R2 ready phase", int'(req_ready), int'(!bus_ph));

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i);

    // back-to-back accesses: strobe gap
    run_vec(VECS[0], 20);
    run_vec(VECS[3], 21);

    // R1 reset in the middle of a stretched strobe
    cfg_wait[2*3 +: 3] = 3'd7;
    cfg_mode[2*2 +: 2] = 2'd0;
    @(negedge clk);
    req_valid = 1'b1;
    req_space = 3'd2;
    for (int g = 0; g < 8 && !req_ready; g++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_wr_n == 1'b0, "R5 mid strobe", int'(bus_wr_n), 0);
    rst_n = 1'b0;
    #1;
    chk(bus_wr_n && bus_sel_n == 6'h3F && !bus_data_oe, "R1 reset abort",
        int'({bus_wr_n, bus_sel_n, bus_data_oe}), int'({1'b1, 6'h3F, 1'b0}));
    @(negedge clk);
    chk(!done, "R1 done cleared", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(bus_wr_n && bus_sel_n == 6'h3F, "R1 stays idle",
        int'({bus_wr_n, bus_sel_n}), int'({1'b1, 6'h3F}));
    have_rise = 1'b0;
    run_vec(VECS[5], 30);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule